// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Mask Save and Restore

The arbiter looks at fourteen interrupt request lines each cycle and picks at most one to take. Seven of the lines are the synchronous exception group: data storage, instruction storage, alignment, program, system call, data translation miss and instruction translation miss. The other seven are asynchronous or critical-class types. The pick is qualified by a four-bit enable word that the block owns. The winner is reported one cycle later as a take strobe and a four-bit cause code. In the same clock edge the enable word is narrowed to match the level that was entered.

There are two handler levels, noncritical and critical. Each level has its own save register. Entering a level copies the enable word into that level's register. A return pulse for the level copies it back.

A small state machine records which levels are active. It has four states:
- `LV_IDLE`: no handler is active.
- `LV_NC`: a noncritical handler is active.
- `LV_CR`: a critical handler is active.
- `LV_BOTH`: both levels are active.

It moves between them on four events: noncritical take, critical take, valid critical return and valid noncritical return. A return pulse counts only when its level is active in that state. The transitions are:
- From `LV_IDLE`: a critical take goes to `LV_CR`; a noncritical take goes to `LV_NC`.
- From `LV_NC`: a critical take goes to `LV_BOTH`; a noncritical return goes to `LV_IDLE`.
- From `LV_CR`: a noncritical take goes to `LV_BOTH`; a critical return goes to `LV_IDLE`.
- From `LV_BOTH`: a critical return goes to `LV_NC`; a noncritical return goes to `LV_CR`.

Entering the noncritical level closes only the external enable. A critical request that is already pending is therefore taken on the very next cycle, before any noncritical handler code runs.

Top module: `irq_arbiter`

## Requirements
- R1: During and straight after reset, `take_o` is 0, `cause_o` is 0 and `mask_o` is 4'b1111. The bit positions are: [0] external enable, [1] critical enable, [2] machine-check enable, [3] debug enable.
- R2: A request is eligible only when its enable bit is 1, with this mapping:
  - external input, fixed-interval timer and decrementer use bit 0;
  - critical input and watchdog use bit 1;
  - machine check uses bit 2;
  - debug uses bit 3;
  - synchronous group requests are always eligible.
- R3: Among eligible requests, the winner is the one with the lowest cause code. Codes 0..6 are the synchronous members in `sync_req` bit order. The remaining codes are: 7 machine check, 8 debug, 9 critical input, 10 watchdog, 11 external input, 12 fixed-interval timer, 13 decrementer.
- R4: Inputs sampled at clock edge N that hold an eligible request, with no return pulse, give `take_o`=1 and the winner's `cause_o` after edge N. `take_o` is 0 after any edge whose sampled inputs hold no eligible request.
- R5: Taking a noncritical type (codes 0..6, 11..13) clears bit 0 and leaves bits 1..3 unchanged. The prior word goes to the noncritical save register.
- R6: Taking critical input or watchdog clears bits 0 and 1 and leaves bits 2 and 3 unchanged. The prior word goes to the critical save register.
- R7: Taking debug clears bits 0, 1 and 3. Taking machine check clears all four bits. Both save the prior word in the critical save register.
- R8: When a synchronous request and a critical-class request are sampled together, the synchronous one is taken first. The critical one is taken on the next edge if it is still asserted.
- R9: No interrupt is taken at an edge where `ret_nc` or `ret_cr` is sampled high.
- R10: A `ret_nc` pulse restores the noncritical save register into the enable word only while the noncritical level is active. At other times it has no effect.
- R11: A `ret_cr` pulse restores the critical save register only while the critical level is active. At other times it has no effect. When both pulses are valid together, only the critical restore happens.
- R12: `cause_o` keeps the code of the last taken interrupt while `take_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_req | input | 7 | Synchronous exception group, at most one bit set |
| mchk_req | input | 1 | Machine check request |
| dbg_req | input | 1 | Debug request |
| crit_req | input | 1 | Critical input request |
| wdog_req | input | 1 | Watchdog timer request |
| ext_req | input | 1 | External input request |
| fit_req | input | 1 | Fixed-interval timer request |
| dec_req | input | 1 | Decrementer request |
| ret_nc | input | 1 | Noncritical return pulse |
| ret_cr | input | 1 | Critical return pulse |
| take_o | output | 1 | One-cycle take strobe |
| cause_o | output | 4 | Cause code of the taken interrupt |
| mask_o | output | 4 | Current enable word |

## Verification
The assertions take for granted that the synchronous group never raises more than one member in a cycle, which the sequential pipeline guarantees. A dedicated check flags any breach of that. The random stimulus draws one member index, or none, per cycle, so it never drives two at once. Every other request line and both return pulses are drawn freely. This includes cycles with both pulses together and pulses for a level that is not active.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int SYNC_N  = 7;
    localparam int ASYNC_N = 7;
    localparam int REQ_N   = SYNC_N + ASYNC_N;
    localparam int CAUSE_W = $clog2(REQ_N + 1);
    localparam int MASK_W  = 4;

    localparam int EE_B = 0;
    localparam int CE_B = 1;
    localparam int ME_B = 2;
    localparam int DE_B = 3;

    localparam logic [MASK_W-1:0] MASK_RST = '1;

    localparam logic [CAUSE_W-1:0] C_MCHK = CAUSE_W'(SYNC_N + 0);
    localparam logic [CAUSE_W-1:0] C_DBG  = CAUSE_W'(SYNC_N + 1);
    localparam logic [CAUSE_W-1:0] C_CRIT = CAUSE_W'(SYNC_N + 2);
    localparam logic [CAUSE_W-1:0] C_WDOG = CAUSE_W'(SYNC_N + 3);
    localparam logic [CAUSE_W-1:0] C_EXT  = CAUSE_W'(SYNC_N + 4);
    localparam logic [CAUSE_W-1:0] C_FIT  = CAUSE_W'(SYNC_N + 5);
    localparam logic [CAUSE_W-1:0] C_DEC  = CAUSE_W'(SYNC_N + 6);

    typedef enum logic [1:0] {
        LV_IDLE = 2'd0,
        LV_NC   = 2'd1,
        LV_CR   = 2'd2,
        LV_BOTH = 2'd3
    } lvl_e;

    function automatic logic cause_is_crit(input logic [CAUSE_W-1:0] c);
        return (c >= C_MCHK) && (c <= C_WDOG);
    endfunction
endpackage

// File: rtl/irq_qualify.sv
module irq_qualify
    import irq_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SYNC_N-1:0]  sync_req,
    input  logic [ASYNC_N-1:0] async_req,
    input  logic [MASK_W-1:0]  mask,
    output logic               hit,
    output logic [CAUSE_W-1:0] cause,
    output logic               is_crit
);
    logic [REQ_N-1:0]   elig;
    logic [ASYNC_N-1:0] async_en;

    // enable bit used by each asynchronous type, in priority order
    assign async_en = {mask[EE_B], mask[EE_B], mask[EE_B],
                       mask[CE_B], mask[CE_B], mask[DE_B], mask[ME_B]};

    genvar g;
    generate
        for (g = 0; g < SYNC_N; g++) begin : g_sync
            assign elig[g] = sync_req[g];
        end
        for (g = 0; g < ASYNC_N; g++) begin : g_async
            assign elig[SYNC_N + g] = async_req[g] & async_en[g];
        end
    endgenerate

    always_comb begin
        hit   = |elig;
        cause = '0;
        for (int i = REQ_N - 1; i >= 0; i--) begin
            if (elig[i]) cause = CAUSE_W'(i);
        end
        is_crit = hit & cause_is_crit(cause);
    end

    // R2
    sync_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sync_req));
endmodule

// File: rtl/irq_level_fsm.sv
module irq_level_fsm
    import irq_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take_nc,
    input  logic take_cr,
    input  logic ret_nc,
    input  logic ret_cr,
    output logic nc_act,
    output logic cr_act,
    output logic nc_ok,
    output logic cr_ok
);
    lvl_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LV_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        nc_act = (state_q == LV_NC) || (state_q == LV_BOTH);
        cr_act = (state_q == LV_CR) || (state_q == LV_BOTH);
        cr_ok  = ret_cr & cr_act;
        nc_ok  = ret_nc & nc_act & ~cr_ok;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LV_IDLE: begin
                if (take_cr)      state_d = LV_CR;
                else if (take_nc) state_d = LV_NC;
            end
            LV_NC: begin
                if (take_cr)      state_d = LV_BOTH;
                else if (nc_ok)   state_d = LV_IDLE;
            end
            LV_CR: begin
                if (take_nc)      state_d = LV_BOTH;
                else if (cr_ok)   state_d = LV_IDLE;
            end
            LV_BOTH: begin
                if (cr_ok)        state_d = LV_NC;
                else if (nc_ok)   state_d = LV_CR;
            end
            default:              state_d = LV_IDLE;
        endcase
    end

    // R10
    nc_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nc_ok |=> !nc_act);

    // R11
    cr_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cr_ok |=> !cr_act);
endmodule

// File: rtl/irq_mask_ctl.sv
module irq_mask_ctl
    import irq_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic [CAUSE_W-1:0] cause,
    input  logic               is_crit,
    input  logic               nc_ok,
    input  logic               cr_ok,
    output logic [MASK_W-1:0]  mask
);
    logic [MASK_W-1:0] mask_q, nc_save_q, cr_save_q;
    logic [MASK_W-1:0] crit_next, ncrit_next;

    always_comb begin
        ncrit_next       = mask_q;
        ncrit_next[EE_B] = 1'b0;
        crit_next        = mask_q;
        crit_next[EE_B]  = 1'b0;
        crit_next[CE_B]  = 1'b0;
        if (cause <= C_DBG)  crit_next[DE_B] = 1'b0;
        if (cause == C_MCHK) crit_next[ME_B] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q    <= MASK_RST;
            nc_save_q <= MASK_RST;
            cr_save_q <= MASK_RST;
        end else if (cr_ok) begin
            mask_q <= cr_save_q;
        end else if (nc_ok) begin
            mask_q <= nc_save_q;
        end else if (take) begin
            if (is_crit) begin
                cr_save_q <= mask_q;
                mask_q    <= crit_next;
            end else begin
                nc_save_q <= mask_q;
                mask_q    <= ncrit_next;
            end
        end
    end

    assign mask = mask_q;

    // R11
    cr_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cr_ok |=> mask_q == $past(cr_save_q));

    // R10
    nc_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nc_ok |=> mask_q == $past(nc_save_q));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SYNC_N-1:0]  sync_req,
    input  logic               mchk_req,
    input  logic               dbg_req,
    input  logic               crit_req,
    input  logic               wdog_req,
    input  logic               ext_req,
    input  logic               fit_req,
    input  logic               dec_req,
    input  logic               ret_nc,
    input  logic               ret_cr,
    output logic               take_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [MASK_W-1:0]  mask_o
);
    logic               hit, is_crit, take_now, ret_any;
    logic [CAUSE_W-1:0] cause;
    logic               nc_act, cr_act, nc_ok, cr_ok;
    logic [ASYNC_N-1:0] async_req;
    logic               take_q;
    logic [CAUSE_W-1:0] cause_q;

    assign async_req = {dec_req, fit_req, ext_req, wdog_req, crit_req, dbg_req, mchk_req};
    assign ret_any   = ret_nc | ret_cr;
    assign take_now  = hit & ~ret_any;

    irq_qualify u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_req (sync_req),
        .async_req(async_req),
        .mask     (mask_o),
        .hit      (hit),
        .cause    (cause),
        .is_crit  (is_crit)
    );

    irq_level_fsm u_lvl (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_nc(take_now & ~is_crit),
        .take_cr(take_now & is_crit),
        .ret_nc (ret_nc),
        .ret_cr (ret_cr),
        .nc_act (nc_act),
        .cr_act (cr_act),
        .nc_ok  (nc_ok),
        .cr_ok  (cr_ok)
    );

    irq_mask_ctl u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take_now),
        .cause  (cause),
        .is_crit(is_crit),
        .nc_ok  (nc_ok),
        .cr_ok  (cr_ok),
        .mask   (mask_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take_q  <= 1'b0;
            cause_q <= '0;
        end else begin
            take_q <= take_now;
            if (take_now) cause_q <= cause;
        end
    end

    assign take_o  = take_q;
    assign cause_o = cause_q;

    // R9
    ret_blocks_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_any |=> !take_o);

    // R5
    nc_keeps_crit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !cause_is_crit(cause_o)) |->
            (!mask_o[EE_B] && mask_o[MASK_W-1:1] == $past(mask_o[MASK_W-1:1])));

    // R6
    crit_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && cause_is_crit(cause_o)) |-> (!mask_o[EE_B] && !mask_o[CE_B]));

    // R7
    mchk_closes_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && cause_o == C_MCHK) |-> (mask_o == '0));

    // R12
    cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> $stable(cause_o));
endmodule

// File: tb/sim_irq_arbiter.sv
`timescale 1ns/1ps
module sim_irq_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] sync_req = '0;
    logic       mchk_req = 0, dbg_req = 0, crit_req = 0, wdog_req = 0;
    logic       ext_req = 0, fit_req = 0, dec_req = 0;
    logic       ret_nc = 0, ret_cr = 0;
    logic       take_o;
    logic [3:0] cause_o, mask_o;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // bench reference state
    logic [3:0] m_mask = 4'hF, m_ncs = 4'hF, m_crs = 4'hF;
    logic       m_nca = 0, m_cra = 0, e_take = 0;
    logic [3:0] e_cause = 0;

    always #4 clk = ~clk;

    irq_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .sync_req(sync_req),
        .mchk_req(mchk_req), .dbg_req(dbg_req), .crit_req(crit_req),
        .wdog_req(wdog_req), .ext_req(ext_req), .fit_req(fit_req),
        .dec_req(dec_req), .ret_nc(ret_nc), .ret_cr(ret_cr),
        .take_o(take_o), .cause_o(cause_o), .mask_o(mask_o)
    );

    function automatic logic eligible(int c);
        if (c < 7)   return sync_req[c];
        if (c == 7)  return mchk_req & m_mask[2];
        if (c == 8)  return dbg_req  & m_mask[3];
        if (c == 9)  return crit_req & m_mask[1];
        if (c == 10) return wdog_req & m_mask[1];
        if (c == 11) return ext_req  & m_mask[0];
        if (c == 12) return fit_req  & m_mask[0];
        return dec_req & m_mask[0];
    endfunction

    function automatic void model_step();
        int win = -1;
        e_take = 0;
        if (ret_nc || ret_cr) begin
            if (ret_cr && m_cra) begin
                m_mask = m_crs; m_cra = 0;
            end else if (ret_nc && m_nca) begin
                m_mask = m_ncs; m_nca = 0;
            end
        end else begin
            for (int c = 13; c >= 0; c--) if (eligible(c)) win = c;
            if (win >= 0) begin
                e_take  = 1;
                e_cause = 4'(win);
                if (win >= 7 && win <= 10) begin
                    m_crs = m_mask;
                    m_mask[0] = 0; m_mask[1] = 0;
                    if (win <= 8) m_mask[3] = 0;
                    if (win == 7) m_mask[2] = 0;
                    m_cra = 1;
                end else begin
                    m_ncs = m_mask;
                    m_mask[0] = 0;
                    m_nca = 1;
                end
            end
        end
    endfunction

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic [6:0] s, input logic [6:0] a,
                       input logic rn, input logic rc, input string tag);
        sync_req = s;
        {dec_req, fit_req, ext_req, wdog_req, crit_req, dbg_req, mchk_req} = a;
        ret_nc = rn; ret_cr = rc;
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk({tag, " take (R4)"},  {3'b0, take_o}, {3'b0, e_take});
        chk({tag, " cause (R3 R12)"}, cause_o, e_cause);
        chk({tag, " mask"}, mask_o, m_mask);
    endtask

    // async bit order: [0] mchk [1] dbg [2] crit [3] wdog [4] ext [5] fit [6] dec
    initial begin
        logic [6:0] s, a;
        int seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        chk("R1 take",  {3'b0, take_o}, 4'h0);
        chk("R1 cause", cause_o, 4'h0);
        chk("R1 mask",  mask_o, 4'hF);

        // R8: synchronous first, then pending critical right after
        cyc(7'b0000100, 7'b0000100, 0, 0, "R8 sync over crit");
        cyc(7'b0, 7'b0000100, 0, 0, "R8 R6 crit preempts");
        // R9 R11: return while request held
        cyc(7'b0, 7'b0000100, 0, 1, "R9 R11 cr return");
        cyc(7'b0, 7'b0, 1, 0, "R10 nc return");
        // R11: critical pulse with no critical level is ignored
        cyc(7'b0, 7'b0010000, 0, 0, "R5 ext take");
        cyc(7'b0, 7'b0, 0, 1, "R11 stray cr pulse");
        cyc(7'b0, 7'b0, 1, 0, "R10 nc return");
        // R10: stray nc pulse
        cyc(7'b0, 7'b0, 1, 0, "R10 stray nc pulse");
        // R7 machine check over everything, then all masked
        cyc(7'b0, 7'b1111111, 0, 0, "R7 mchk");
        cyc(7'b0, 7'b1111110, 0, 0, "R2 R12 all masked");
        cyc(7'b0, 7'b0, 0, 1, "R11 cr return");
        // R7 debug
        cyc(7'b0, 7'b0000110, 0, 0, "R7 dbg");
        cyc(7'b0, 7'b0, 0, 1, "R11 cr return");
        // R6 watchdog over external
        cyc(7'b0, 7'b0011000, 0, 0, "R6 wdog");
        cyc(7'b0, 7'b0, 0, 1, "R11 cr return");
        // R3 timers
        cyc(7'b0, 7'b1100000, 0, 0, "R3 fit");
        cyc(7'b0, 7'b1000000, 0, 0, "R2 dec masked");
        cyc(7'b0, 7'b0, 1, 0, "R10 nc return");
        cyc(7'b0, 7'b1000000, 0, 0, "R3 dec");
        // R2 synchronous unmaskable
        cyc(7'b1000000, 7'b0, 0, 0, "R2 sync with ee clear");
        cyc(7'b0, 7'b0, 1, 1, "R11 both pulses");
        cyc(7'b0, 7'b0, 1, 0, "R10 nc return");
        cyc(7'b0, 7'b0, 1, 0, "R10 nc return");

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            s = '0;
            if ($urandom_range(5) == 0) s[$urandom_range(6)] = 1'b1;
            a = 7'($urandom) & 7'($urandom);
            cyc(s, a, $urandom_range(5) == 0, $urandom_range(5) == 0, "R2 R3 R5 R6 R7 R10 R11 rand");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule